// File: doc/BRIEF.md
# Timer Terminal-Count Interrupt Aggregator

This block watches the terminal-count outputs of three interval timers, numbered 3, 4 and 5, and turns each 0-to-1 transition into a sticky status bit. Software clears a status bit by writing 1 to it. Each source has its own mask. When the global enable is set, the block raises a single request and steers it onto one of sixteen legacy IRQ lines. A 3-bit code picks the line, and the eight usable lines are not contiguous.

The block also holds one clock-source bit per timer and drives it out to the timers. A value of 0 selects the internal clock, which is the bus clock divided by 8 (about 4.167 MHz). A value of 1 selects the external clock pin.

The block has three write ports, each with its own strobe and one shared 8-bit data bus:

- **Configuration word:** bit 0 is the global enable. Bits 3:1 are the IRQ select. Bits 6:4 are the masks for timers 3, 4 and 5. Bit 7 is reserved.
- **Status clear word:** bits 2:0 clear the status bits of timers 3, 4 and 5. Bits 7:3 are reserved.
- **Clock-source word:** bits 2:0 are the clock-source bits of timers 3, 4 and 5. Bits 7:3 are reserved.

Each timer input is asynchronous. It passes through a two-flop synchronizer before the edge detector.

Top module: `tcirq_agg`

## Requirements
- R1: After reset, all of these are 0: status, enable, masks and clock-source outputs. The select field is 000, which means IRQ3. No IRQ line is driven.
- R2: A status bit sets on a 0-to-1 transition of its timer input. It becomes visible on status_o by the third rising clock edge after the input rises. A level that stays high does not set the bit again after it has been cleared.
- R3: Writing the status word with a bit at 1 clears that status bit. A bit at 0 leaves its status bit unchanged.
- R4: If a rising edge and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up at 1.
- R5: When the enable is 1 and any status bit whose mask is 1 is set, irq_req_o is 1 and exactly one bit of irq_o is 1.
- R6: A status bit whose mask is 0 does not cause a request.
- R7: When the enable is 0, irq_req_o is 0 and irq_o is all zero, whatever the select field holds.
- R8: The select code picks the driven line: 000 gives IRQ3, 001 gives IRQ4, 010 gives IRQ5, 011 gives IRQ10, 100 gives IRQ6, 101 gives IRQ7, 110 gives IRQ9 and 111 gives IRQ11. IRQ n is irq_o[n].
- R9: After a write to the clock-source word, clk_ext_o equals bits 2:0 of the written data. A bit at 1 selects the external clock for that timer.
- R10: Reserved bits in every word have no effect. Bit 7 of the configuration word, bits 7:3 of the status word and bits 7:3 of the clock-source word change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tc_i | input | 3 | Terminal-count outputs of timers 3, 4 and 5 (asynchronous) |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| stat_we_i | input | 1 | Write strobe for the status word (write 1 to clear) |
| clk_we_i | input | 1 | Write strobe for the clock-source word |
| wdata_i | input | 8 | Write data |
| status_o | output | 3 | Sticky status bits |
| irq_req_o | output | 1 | Combined request before steering |
| irq_o | output | 16 | Legacy IRQ lines, at most one high |
| clk_ext_o | output | 3 | Per-timer clock source: 1 for external, 0 for internal |

## Verification
The assertions assume the following about the inputs:

- **Strobes:** they are synchronous to clk_i and never overlap one another.
- **Timer inputs:** each holds its level long enough for the synchronizer to capture it.

The stimulus changes every input only at the falling edge. It raises one strobe at a time, and it holds each timer level for at least four cycles. The set-versus-clear collision is the one deliberate exception to the spacing. In that case the clear strobe is placed in the exact cycle in which the synchronized edge appears.

// File: rtl/tcirq_pkg.sv
package tcirq_pkg;
  localparam int N_SRC     = 3;
  localparam int DATA_W    = 8;
  localparam int IRQ_LINES = 16;
  localparam int SEL_W     = 3;

  // configuration word layout
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_SEL_LSB  = 1;
  localparam int CFG_MASK_LSB = 4;

  // select code to legacy IRQ number
  function automatic logic [3:0] irq_line(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    irq_line = 4'd3;
      3'd1:    irq_line = 4'd4;
      3'd2:    irq_line = 4'd5;
      3'd3:    irq_line = 4'd10;
      3'd4:    irq_line = 4'd6;
      3'd5:    irq_line = 4'd7;
      3'd6:    irq_line = 4'd9;
      default: irq_line = 4'd11;
    endcase
  endfunction
endpackage

// File: rtl/tcirq_sync_edge.sv
module tcirq_sync_edge #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] sync_q [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // a detected rise leaves the remembered level high
  p_rise_updates_prev_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_o) |=> ((prev_q & $past(rise_o)) == $past(rise_o)));
endmodule

// File: rtl/tcirq_status.sv
module tcirq_status #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] status_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> status_q[i]);
    p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !status_q[i]);
    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[i] && !set_i[i]) |=> $stable(status_q[i]));
  end
endmodule

// File: rtl/tcirq_route.sv
module tcirq_route
  import tcirq_pkg::*;
#(
  parameter int N     = 3,
  parameter int LINES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N-1:0]     mask_i,
  input  logic [N-1:0]     status_i,
  output logic             req_o,
  output logic [LINES-1:0] irq_o
);
  assign req_o = en_i & (|(status_i & mask_i));

  always_comb begin
    irq_o = '0;
    if (req_o) irq_o[irq_line(sel_i)] = 1'b1;
  end

  p_single_line_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
  p_quiet_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (irq_o == '0));
endmodule

// File: rtl/tcirq_agg.sv
module tcirq_agg
  import tcirq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_SRC-1:0]     tc_i,
  input  logic                 cfg_we_i,
  input  logic                 stat_we_i,
  input  logic                 clk_we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [N_SRC-1:0]     status_o,
  output logic                 irq_req_o,
  output logic [IRQ_LINES-1:0] irq_o,
  output logic [N_SRC-1:0]     clk_ext_o
);
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] clk_q;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      mask_q <= '0;
      clk_q  <= '0;
    end else begin
      if (cfg_we_i) begin
        en_q   <= wdata_i[CFG_EN_BIT];
        sel_q  <= wdata_i[CFG_SEL_LSB +: SEL_W];
        mask_q <= wdata_i[CFG_MASK_LSB +: N_SRC];
      end
      if (clk_we_i) clk_q <= wdata_i[N_SRC-1:0];
    end
  end

  // reserved data bits are accepted and dropped
  logic unused_rsvd;
  assign unused_rsvd = ^wdata_i[DATA_W-1:CFG_MASK_LSB+N_SRC];

  assign clr       = stat_we_i ? wdata_i[N_SRC-1:0] : '0;
  assign clk_ext_o = clk_q;

  tcirq_sync_edge #(.N(N_SRC), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .async_i(tc_i), .rise_o(rise)
  );

  tcirq_status #(.N(N_SRC)) u_status (
    .clk_i, .rst_ni, .set_i(rise), .clr_i(clr), .status_o(status_o)
  );

  tcirq_route #(.N(N_SRC), .LINES(IRQ_LINES)) u_route (
    .clk_i, .rst_ni, .en_i(en_q), .sel_i(sel_q), .mask_i(mask_q),
    .status_i(status_o), .req_o(irq_req_o), .irq_o(irq_o)
  );

  p_req_on_masked_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && |(status_o & mask_q)) |-> (irq_o != '0));
  p_masked_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & mask_q) == '0) |-> !irq_req_o);
  p_clk_sel_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_we_i |=> (clk_ext_o == $past(wdata_i[N_SRC-1:0])));
endmodule

// File: tb/tcirq_agg_bench.sv
module tcirq_agg_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  tc_i = '0;
  logic        cfg_we_i = 1'b0, stat_we_i = 1'b0, clk_we_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [2:0]  status_o;
  logic        irq_req_o;
  logic [15:0] irq_o;
  logic [2:0]  clk_ext_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  tcirq_agg u_tcirq_agg (.*);

  // {sel[7:5], irq number[4:0]}
  localparam logic [7:0] SEL_TAB [8] = '{8'h03, 8'h24, 8'h45, 8'h6A,
                                         8'h86, 8'hA7, 8'hC9, 8'hEB};

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int port, input logic [7:0] d);
    wdata_i = d;
    cfg_we_i = (port == 0); stat_we_i = (port == 1); clk_we_i = (port == 2);
    @(negedge clk_i);
    cfg_we_i = 0; stat_we_i = 0; clk_we_i = 0; wdata_i = '0;
  endtask

  task automatic set_tc(input int idx, input logic v);
    tc_i[idx] = v;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 status", status_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 clk", clk_ext_o, 0);

    set_tc(0, 1);
    check("R2 rise sets", status_o, 3'b001);
    check("R7 disabled req", irq_req_o, 0);
    wr(1, 8'h01);
    check("R3 clear", status_o, 0);
    repeat (4) @(negedge clk_i);
    check("R2 level no reset", status_o, 0);
    set_tc(0, 0);
    set_tc(1, 1);
    set_tc(2, 1);
    check("R2 two rises", status_o, 3'b110);
    wr(1, 8'h00);
    check("R3 write zero", status_o, 3'b110);
    wr(1, 8'hF8);
    check("R10 reserved stat", status_o, 3'b110);

    wr(0, 8'h76);
    check("R7 en off irq", irq_o, 0);
    check("R7 en off req", irq_req_o, 0);
    wr(0, 8'hF6);
    check("R10 reserved cfg", irq_o, 0);

    for (int k = 0; k < 8; k++) begin
      wr(0, 8'h71 | {4'b0, SEL_TAB[k][7:5], 1'b0});
      check("R8 line map", irq_o, 1 << SEL_TAB[k][4:0]);
      check("R5 req", irq_req_o, 1);
    end

    wr(0, 8'h11);
    check("R6 masked req", irq_req_o, 0);
    check("R6 masked irq", irq_o, 0);
    wr(0, 8'h21);
    check("R5 unmasked irq3", irq_o, 16'h0008);

    wr(2, 8'hFD);
    check("R9 clk sel", clk_ext_o, 3'b101);
    wr(2, 8'h02);
    check("R9 clk sel 2", clk_ext_o, 3'b010);

    // R4: clear lands in the cycle the synchronized edge appears
    wr(1, 8'h07);
    check("R3 clear all", status_o, 0);
    set_tc(0, 1);
    wr(1, 8'h00);
    set_tc(0, 0);
    check("R4 setup", status_o, 3'b001);
    tc_i[0] = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    wr(1, 8'h01);
    check("R4 set wins", status_o, 3'b001);
    wr(1, 8'h01);
    check("R4 later clear", status_o, 0);

    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 reset clk", clk_ext_o, 0);
    check("R1 reset irq", irq_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule